// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block collects interrupt requests from a set of devices, each on its own wire. A rising edge on a wire marks that line pending in a sticky register. A per-line enable register and one global enable decide which pending lines may reach the processor. A priority encoder picks the winner among the lines that are pending and enabled, and presents its vector together with a single interrupt output.

A separate non-maskable input has its own sticky pending bit. That bit ignores both the per-line enables and the global enable, and it outranks every maskable line. Software writes the enables through a narrow register write port. When the handler starts, it acknowledges by returning the vector it was given, and that vector's pending bit is cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the vector output is zero, every pending bit is clear, all per-line enables are 0 and the global enable is 0.
- R2: A request line sets its pending bit on the clock edge where it is sampled high after being sampled low. A line held high does not set the bit again after that bit has been acknowledged.
- R3: A pending bit stays set until an acknowledge carries that line's own vector. An acknowledge carrying any other vector leaves the bit unchanged.
- R4: A pending line whose enable bit is 0 is not presented. It stays pending, and it is presented once its enable bit is written to 1.
- R5: While the global enable is 0, no maskable line drives the interrupt output.
- R6: Among the lines that are pending and enabled, the lowest index wins. The vector for line i is VEC_BASE + i.
- R7: A rising edge on the non-maskable input sets a pending bit that drives the interrupt output with vector NMI_VEC, whatever the enables hold. It takes precedence over all maskable lines and is cleared by an acknowledge of NMI_VEC.
- R8: The interrupt output is high exactly when the non-maskable bit, or at least one pending and enabled line, is set. While the interrupt output is low, the vector output is zero.
- R9: If a new rising edge and an acknowledge of the same line fall on the same clock edge, the line stays pending.
- R10: A write with address 0 loads the per-line enables from wr_data_i (bit i enables line i, 1 = enabled). A write with address 1 loads the global enable from wr_data_i bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_LINES | Maskable request lines, one per device |
| nmi_i | input | 1 | Non-maskable request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 per-line enables, 1 global enable |
| wr_data_i | input | N_LINES | Write data |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | VEC_W | Vector being acknowledged |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector of the winning request, zero when idle |

## Verification
A lost or stuck pending bit appears at the ports on the cycle after the event that should have changed it. It shows as a missing interrupt, a vector that does not move after its acknowledge, or a stale vector that comes back after the global or per-line enable is raised. A wrong enable register shows on the cycle after the write, because irq_o rises or falls against the pending state the bench has built. A priority or offset fault shows as a wrong vector while two or more lines are pending, so the bench raises several lines at once and acknowledges them one by one to walk the whole order.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    CFG_MASK = 1'b0,
    CFG_GIE  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/irq_pend_bit.sv
module irq_pend_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic req_q;
  logic set;

  assign set = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      req_q  <= req_i;
      // new edge wins over a coincident clear
      pend_o <= set | (pend_o & ~clr_i);
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [N_LINES-1:0] wr_data_i,
  output logic [N_LINES-1:0] mask_o,
  output logic               gie_o
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      gie_o  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (sel)
        CFG_MASK: mask_o <= wr_data_i;
        CFG_GIE:  gie_o  <= wr_data_i[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] act_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    valid_o = |act_i;
    idx_o   = '0;
    // scan downward so the lowest index is assigned last
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned    N_LINES  = 8,
  parameter int unsigned    VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
  parameter logic [VEC_W-1:0] NMI_VEC  = 8'h02
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               nmi_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic               ack_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] clr;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] act;
  logic               gie_q;
  logic               nmi_pend_q;
  logic               nmi_clr;
  logic               enc_valid;
  logic [IDX_W-1:0]   enc_idx;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign clr[g] = ack_i && (ack_vec_i == VEC_BASE + VEC_W'(g));

    irq_pend_bit u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[g]),
      .clr_i  (clr[g]),
      .pend_o (pend_q[g])
    );
  end

  assign nmi_clr = ack_i && (ack_vec_i == NMI_VEC);

  irq_pend_bit u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend_q)
  );

  irq_cfg_regs #(.N_LINES(N_LINES)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_q),
    .gie_o     (gie_q)
  );

  assign act = pend_q & mask_q & {N_LINES{gie_q}};

  irq_prio_enc #(.N_LINES(N_LINES)) u_enc (
    .act_i   (act),
    .valid_o (enc_valid),
    .idx_o   (enc_idx)
  );

  always_comb begin
    irq_o = nmi_pend_q | enc_valid;
    if (nmi_pend_q)     vec_o = NMI_VEC;
    else if (enc_valid) vec_o = VEC_BASE + VEC_W'(enc_idx);
    else                vec_o = '0;
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int unsigned    N_LINES  = 8,
  parameter int unsigned    VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h20,
  parameter logic [VEC_W-1:0] NMI_VEC  = 8'h02
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] req_i,
  input logic               ack_i,
  input logic [VEC_W-1:0]   ack_vec_i,
  input logic [N_LINES-1:0] pend_q,
  input logic               nmi_pend_q,
  input logic               gie_q,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o
);
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0); // R8

  AST_NMI_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend_q |-> irq_o && vec_o == NMI_VEC); // R7

  AST_GIE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q && !nmi_pend_q |-> !irq_o); // R5

  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !nmi_pend_q |-> vec_o >= VEC_BASE && vec_o < VEC_BASE + VEC_W'(N_LINES)); // R6

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_i[g]) |=> pend_q[g]); // R2

    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[g] && !(ack_i && ack_vec_i == VEC_BASE + VEC_W'(g)) |=> pend_q[g]); // R3
  end
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .N_LINES(N_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ack_i      (ack_i),
  .ack_vec_i  (ack_vec_i),
  .pend_q     (pend_q),
  .nmi_pend_q (nmi_pend_q),
  .gie_q      (gie_q),
  .irq_o      (irq_o),
  .vec_o      (vec_o)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int VW = 8;
  localparam logic [VW-1:0] BASE = 8'h20;
  localparam logic [VW-1:0] NMIV = 8'h02;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          nmi_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_addr_i = 1'b0;
  logic [N-1:0]  wr_data_i = '0;
  logic          ack_i = 1'b0;
  logic [VW-1:0] ack_vec_i = '0;
  logic          irq_o;
  logic [VW-1:0] vec_o;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  prio_irq_ctrl #(.N_LINES(N), .VEC_W(VW), .VEC_BASE(BASE), .NMI_VEC(NMIV)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .nmi_i(nmi_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .ack_vec_i(ack_vec_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic chk(string rq, logic irq_exp, logic [VW-1:0] vec_exp);
    total++;
    if (irq_o !== irq_exp || vec_o !== vec_exp) begin
      bad++;
      $display("FAIL %s: irq=%0b vec=%02h expected irq=%0b vec=%02h",
               rq, irq_o, vec_o, irq_exp, vec_exp);
    end
  endtask

  task automatic wr(logic a, logic [N-1:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic ack(logic [VW-1:0] v);
    @(negedge clk_i); ack_i = 1'b1; ack_vec_i = v;
    @(negedge clk_i); ack_i = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] lines);
    @(negedge clk_i); req_i = lines;
    @(negedge clk_i); req_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset", 1'b0, '0);
  endtask

  task automatic t_gie;
    wr(1'b0, 8'hFF);
    pulse(8'h20);
    chk("R5 gie off blocks", 1'b0, '0);
    wr(1'b1, 8'h01);
    chk("R10 gie write presents line5", 1'b1, BASE + 5);
    ack(BASE + 5);
    chk("R8 idle after ack", 1'b0, '0);
  endtask

  task automatic t_priority;
    pulse(8'h44);
    chk("R6 lowest index wins", 1'b1, BASE + 2);
    ack(BASE + 2);
    chk("R6 next line after ack", 1'b1, BASE + 6);
    ack(BASE + 6);
    chk("R8 idle", 1'b0, '0);
  endtask

  task automatic t_mask;
    wr(1'b0, 8'hEF);
    pulse(8'h10);
    chk("R4 masked line hidden", 1'b0, '0);
    wr(1'b0, 8'hFF);
    chk("R4 unmasked line presented", 1'b1, BASE + 4);
    ack(BASE + 4);
  endtask

  task automatic t_sticky;
    pulse(8'h02);
    ack(BASE + 7);
    chk("R3 other ack keeps pending", 1'b1, BASE + 1);
    ack(BASE + 1);
    chk("R3 own ack clears", 1'b0, '0);
  endtask

  task automatic t_level;
    @(negedge clk_i); req_i = 8'h08;
    @(negedge clk_i);
    chk("R2 edge sets pending", 1'b1, BASE + 3);
    ack(BASE + 3);
    chk("R2 held level no retrigger", 1'b0, '0);
    @(negedge clk_i); req_i = '0;
    pulse(8'h08);
    chk("R2 new edge sets again", 1'b1, BASE + 3);
    ack(BASE + 3);
  endtask

  task automatic t_nmi;
    pulse(8'h01);
    chk("R6 line0 vector", 1'b1, BASE);
    @(negedge clk_i); nmi_i = 1'b1;
    @(negedge clk_i); nmi_i = 1'b0;
    chk("R7 nmi beats line0", 1'b1, NMIV);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    chk("R7 nmi ignores enables", 1'b1, NMIV);
    ack(NMIV);
    chk("R5 gie off after nmi ack", 1'b0, '0);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h01);
    chk("R4 line0 still pending", 1'b1, BASE);
    ack(BASE);
    chk("R8 idle", 1'b0, '0);
  endtask

  task automatic t_coincide;
    pulse(8'h80);
    chk("R9 line7 pending", 1'b1, BASE + 7);
    @(negedge clk_i); req_i = 8'h80; ack_i = 1'b1; ack_vec_i = BASE + 7;
    @(negedge clk_i); req_i = '0; ack_i = 1'b0;
    chk("R9 edge beats coincident ack", 1'b1, BASE + 7);
    ack(BASE + 7);
    chk("R9 cleared afterwards", 1'b0, '0);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_gie();
    t_priority();
    t_mask();
    t_sticky();
    t_level();
    t_nmi();
    t_coincide();
    repeat (2) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule